// File: doc/BRIEF.md
# Sorted-Request Output Contention Arbiter

This block settles which requester may use each outlet of an input-queued cell switch in one time slot. A sorting stage ahead of it places one request per lane. Requests are ordered by destination and then by source, so all requests for one outlet sit on neighbouring lanes. Each lane gives a valid flag and a parallel source number. Each lane also gives a destination that arrives one bit per cycle, most significant bit first. A start strobe marks the first bit.

Each lane keeps a sticky mismatch flag. The flag is set at the first destination bit that differs from the lane directly below. A valid lane wins its outlet when it is lane 0, when the lane below is empty, or when the flag shows a different destination. The result is encoded 0 for a win and 1 for a loss. The acknowledgement for each lane is the lane's source number followed by its grant bit. Sources are unique, so these acknowledgements can be routed back to their requesters without collision. A requester that reads a loss keeps its head-of-line cell and asks again in the next slot.

Top module: `sorted_contention_arbiter`

## Requirements
- R1: While reset is held and after it is released, `done` is 0, every bit of `grant_n` is 1, and every acknowledgement holds source 0 with grant bit 1.
- R2: The first destination bit (MSB) is presented in the cycle where `dst_start` is high, and one bit follows in each of the next log2(N)-1 cycles. `done` is high for exactly the one cycle after the cycle that carries the last bit (LSB).
- R3: When `done` is high, lane 0 shows grant 0 if it was valid and 1 if it was not.
- R4: When `done` is high, a valid lane i>0 shows grant 0 exactly when lane i-1 was invalid or the two destinations differ in at least one bit. Otherwise it shows grant 1.
- R5: For a sorted input (valid lanes first, in non-decreasing destination/source order), each destination that is requested gets exactly one winner, on the lowest lane of its run.
- R6: An invalid lane shows grant 1, and its destination bits do not affect the lane above it.
- R7: The comparison history is cleared by `dst_start`. A mismatch seen in an earlier slot, or destination bits applied outside the comparison window, do not affect the result.
- R8: Acknowledgement field i (bits [i*(n+1) +: n+1]) is {source of lane i sampled with the last destination bit, grant bit of lane i}, with the grant bit in the LSB.
- R9: `grant_n` and `ack_out` do not change except in the cycle where `done` is high.
- R10: A difference in any single bit position, whether MSB or LSB, counts as a different destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dst_start | input | 1 | High with the MSB of a new destination comparison |
| dst_bit | input | N | Current serial destination bit of each lane |
| req_valid | input | N | Lane carries a request; sampled with the last bit |
| src_in | input | N*n | Source number of each lane, n bits per lane |
| done | output | 1 | One-cycle pulse: results updated |
| grant_n | output | N | Per-lane grant, 0 = winner, 1 = loser |
| ack_out | output | N*(n+1) | Per-lane {source, grant} acknowledgement |

## Verification
The bench builds the block with N=8, so n=3. Each comparison then lasts three cycles, and both the MSB and LSB cases of the sticky flag can be reached. With eight lanes the bench can form a full run of one destination, a full permutation with no contention, and mixed runs with empty lanes at the tail. A behavioural sorter orders the requests. A requester model re-issues the losing requests slot after slot until all of them are served. Some directed slots feed unsorted lanes with an empty lane in the middle, to show that an empty lane does not block the lane above it. Slots run both back to back and with idle gaps, and random bits are applied during the gaps.

// File: rtl/sorted_contention_arbiter.sv
module sorted_contention_arbiter #(
  parameter int N = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dst_start,
  input  logic [N-1:0]             dst_bit,
  input  logic [N-1:0]             req_valid,
  input  logic [N*$clog2(N)-1:0]   src_in,
  output logic                     done,
  output logic [N-1:0]             grant_n,
  output logic [N*($clog2(N)+1)-1:0] ack_out
);
  localparam int SW = $clog2(N);
  localparam int CW = $clog2(SW) + 1;

  logic [CW-1:0]   bit_idx, cur_idx;
  logic            busy, active, last;
  logic [N-1:1]    mis, mis_next, diff;
  logic [N-1:0]    win;
  logic [N*SW-1:0] src_q;

  assign active  = dst_start | busy;
  assign cur_idx = dst_start ? '0 : bit_idx;
  assign last    = active && (cur_idx == CW'(SW - 1));

  for (genvar i = 1; i < N; i++) begin : g_cmp
    assign diff[i]     = dst_bit[i] ^ dst_bit[i-1];
    assign mis_next[i] = (dst_start ? 1'b0 : mis[i]) | diff[i];
    assign win[i]      = req_valid[i] & (~req_valid[i-1] | mis_next[i]);
  end
  assign win[0] = req_valid[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      mis     <= '0;
    end else if (active) begin
      mis <= mis_next;
      if (last) begin
        busy    <= 1'b0;
        bit_idx <= '0;
      end else begin
        busy    <= 1'b1;
        bit_idx <= cur_idx + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      grant_n <= '1;
      src_q   <= '0;
    end else begin
      done <= last;
      if (last) begin
        grant_n <= ~win;
        src_q   <= src_in;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_ack
    assign ack_out[i*(SW+1) +: SW+1] = {src_q[i*SW +: SW], grant_n[i]};
  end
endmodule

// File: rtl/arbiter_checker.sv
module arbiter_checker #(
  parameter int N = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        dst_start,
  input logic [N-1:0]                req_valid,
  input logic                        done,
  input logic [N-1:0]                grant_n,
  input logic [N*($clog2(N)+1)-1:0]  ack_out
);
  localparam int SW = $clog2(N);
  int cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= 0;
    else if (dst_start) cnt <= 1;
    else if (cnt != 0 && cnt < SW) cnt <= cnt + 1;
    else cnt <= 0;
  end

  p_done_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == SW));

  p_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (grant_n[0] == !$past(req_valid[0])));

  p_invalid_loses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((~$past(req_valid) & ~grant_n) == '0));

  p_empty_below_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(req_valid[1]) && !$past(req_valid[0])) |-> !grant_n[1]);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(grant_n) && $stable(ack_out)));

  for (genvar i = 0; i < N; i++) begin : g_ack
    p_ack_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_out[i*(SW+1)] == grant_n[i]);
  end
endmodule

bind sorted_contention_arbiter arbiter_checker #(.N(N)) u_chk (.*);

// File: tb/tb_sorted_contention_arbiter.sv
module tb_sorted_contention_arbiter;
  localparam int N  = 8;
  localparam int SW = 3;
  localparam int AW = SW + 1;

  logic clk = 1'b0, rst_n = 1'b0, dst_start = 1'b0;
  logic [N-1:0] dst_bit = '0, req_valid = '0;
  logic [N*SW-1:0] src_in = '0;
  logic done;
  logic [N-1:0] grant_n;
  logic [N*AW-1:0] ack_out;

  always #5 clk = ~clk;

  sorted_contention_arbiter #(.N(N)) dut (.*);

  typedef struct packed {
    logic [N-1:0]    g;
    logic [N*AW-1:0] ack;
    logic [N-1:0]    v;
    logic [N*SW-1:0] d;
    logic            sorted;
  } exp_t;

  exp_t q[$];
  exp_t last_exp;
  int checks = 0, fails = 0;
  bit finished = 0;

  int lane_d[N], lane_s[N];
  bit lane_v[N];
  int req_d[N];
  bit req_v[N];
  bit req_won[N];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive the current lane arrays for one slot; gap idle cycles afterwards
  task automatic run_lanes(bit sorted, int gap);
    exp_t e;
    bit w;
    e = '0;
    e.sorted = sorted;
    for (int i = 0; i < N; i++) begin
      w = lane_v[i] && (i == 0 || !lane_v[i-1] || lane_d[i] != lane_d[i-1]);
      e.g[i] = !w;
      e.v[i] = lane_v[i];
      e.d[i*SW +: SW] = SW'(lane_d[i]);
      e.ack[i*AW +: AW] = {SW'(lane_s[i]), !w};
    end
    q.push_back(e);
    for (int b = SW - 1; b >= 0; b--) begin
      dst_start = (b == SW - 1);
      for (int i = 0; i < N; i++) begin
        dst_bit[i]        = (lane_d[i] >> b) & 1;
        req_valid[i]      = lane_v[i];
        src_in[i*SW +: SW] = SW'(lane_s[i]);
      end
      @(negedge clk);
      if (b != 0) chk(done == 1'b0, "R2", "done early", done, 0);
      else        chk(done == 1'b1, "R2", "done after last bit", done, 1);
    end
    dst_start = 1'b0;
    for (int k = 0; k < gap; k++) begin
      dst_bit   = N'($urandom);
      req_valid = N'($urandom);
      src_in    = (N*SW)'($urandom);
      @(negedge clk);
      chk(done == 1'b0, "R2", "done single cycle", done, 0);
    end
  endtask

  // behavioural sorter: requester i has source i
  task automatic sort_and_run(int gap);
    int key[N], idx[N], t;
    for (int i = 0; i < N; i++) begin
      idx[i] = i;
      key[i] = req_v[i] ? req_d[i] * N + i : N * N + i;
    end
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N - 1 - a; b++)
        if (key[idx[b]] > key[idx[b+1]]) begin
          t = idx[b]; idx[b] = idx[b+1]; idx[b+1] = t;
        end
    for (int i = 0; i < N; i++) begin
      lane_v[i] = req_v[idx[i]];
      lane_d[i] = req_v[idx[i]] ? req_d[idx[i]] : int'($urandom_range(N-1));
      lane_s[i] = idx[i];
    end
    for (int i = 0; i < N; i++) begin
      req_won[idx[i]] = lane_v[i] && (i == 0 || !lane_v[i-1] || lane_d[i] != lane_d[i-1]);
    end
    run_lanes(1'b1, gap);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (q.size() == 0) begin
          chk(0, "R2", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(grant_n[0] == e.g[0], "R3", "lane0 grant", grant_n[0], e.g[0]);
          chk(grant_n == e.g, "R4", "grant vector", grant_n, e.g);
          chk(((~e.v) & ~grant_n) == '0, "R6", "invalid lanes lose", grant_n, e.g);
          chk(ack_out == e.ack, "R8", "ack fields", ack_out, e.ack);
          if (e.sorted) begin
            for (int dv = 0; dv < N; dv++) begin
              int req, win;
              req = 0; win = 0;
              for (int i = 0; i < N; i++)
                if (e.v[i] && int'(e.d[i*SW +: SW]) == dv) begin
                  req++;
                  if (!grant_n[i]) win++;
                end
              if (req > 0) chk(win == 1, "R5", "winners per outlet", win, 1);
            end
          end
          last_exp = e;
        end
      end else begin
        chk(grant_n == last_exp.g && ack_out == last_exp.ack, "R9", "hold", grant_n, last_exp.g);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int rounds;
    bit pend;
    last_exp = '0;
    last_exp.g = '1;
    for (int i = 0; i < N; i++) last_exp.ack[i*AW] = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && grant_n == '1 && ack_out == last_exp.ack, "R1", "in reset", grant_n, '1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 1'b0 && grant_n == '1 && ack_out == last_exp.ack, "R1", "after reset", ack_out, last_exp.ack);

    for (int i = 0; i < N; i++) begin req_v[i] = 0; req_d[i] = 0; end
    sort_and_run(1);                                     // R6 all empty
    for (int i = 0; i < N; i++) begin req_v[i] = 1; req_d[i] = 3; end
    sort_and_run(0);                                     // R5 one run of eight
    for (int i = 0; i < N; i++) begin req_d[i] = (i * 5 + 2) % N; end
    sort_and_run(2);                                     // R4 permutation

    // R10: LSB-only and MSB-only differences
    for (int i = 0; i < N; i++) req_v[i] = 0;
    req_v[0] = 1; req_d[0] = 4; req_v[1] = 1; req_d[1] = 5;
    req_v[2] = 1; req_d[2] = 0; req_v[3] = 1; req_d[3] = 4;
    sort_and_run(1);

    // R7: mismatch in one slot, equal destinations in the next
    for (int i = 0; i < N; i++) req_v[i] = 0;
    req_v[0] = 1; req_d[0] = 1; req_v[1] = 1; req_d[1] = 5;
    sort_and_run(0);
    req_d[0] = 2; req_d[1] = 2;
    sort_and_run(3);

    // R6: empty lane in the middle does not block the lane above
    for (int i = 0; i < N; i++) begin lane_v[i] = 0; lane_d[i] = 2; lane_s[i] = i; end
    lane_v[0] = 1; lane_v[2] = 1; lane_v[4] = 1; lane_d[4] = 7;
    run_lanes(1'b0, 1);

    // R4 R5: losers re-issue until every requester is served
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < N; i++) begin req_v[i] = 1; req_d[i] = $urandom_range(N-1); end
      rounds = 0;
      pend = 1;
      while (pend && rounds < N) begin
        sort_and_run($urandom_range(2));
        for (int i = 0; i < N; i++) if (req_won[i]) req_v[i] = 0;
        rounds++;
        pend = 0;
        for (int i = 0; i < N; i++) if (req_v[i]) pend = 1;
      end
      chk(!pend, "R4", "all requesters served", rounds, N);
    end

    // random sorted slots
    for (int r = 0; r < 150; r++) begin
      for (int i = 0; i < N; i++) begin req_v[i] = $urandom_range(1); req_d[i] = $urandom_range(N-1); end
      sort_and_run($urandom_range(2));
    end

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2", "all results seen", q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule